// File: doc/BRIEF.md
# Self-Correcting Overscaled Multiplier

This block is an unsigned L×L multiplier that returns the exact 2L-bit product even when the upper part of its main multiplier's result is wrong. It models a datapath run below its safe supply voltage. In that condition the longest carry paths, which end in the high product bits, miss the clock. The low M bits still settle in time. A small replica multiplier works on the top P bits of each operand and produces an estimate of the product. The estimate always falls short of the true product by less than 2^M. Timing damage changes the main result by a multiple of 2^M. Subtracting the estimate from the damaged result and clearing the low M bits therefore gives the damage exactly, and removing it gives the true product.

A fault-injection input flips chosen high bits of the main multiplier's result, standing in for timing failures in simulation. Mask bits inside the safe low field have no effect. An operand pair offered with `in_valid` appears on the output one clock later with `out_valid`. When `in_valid` is low, the output register keeps its value. The compile-time parameters are L, the operand width, and M, the safe field width. P is derived as 2L−M+1 and must be less than L.

Top module: `ovs_mult`

## Requirements
- R1: One clock edge after a cycle with `in_valid` high, `prod_out` equals `op_a*op_b` exactly as a 2L-bit unsigned value, for any `err_mask`.
- R2: Bit i of `err_mask` flips bit i of the main multiplier's result only for i ≥ M. Mask bits 0..M−1 are ignored, so a mask confined to them gives the same output as an all-zero mask.
- R3: `out_valid` at a clock edge equals `in_valid` sampled at the previous edge when reset is not active.
- R4: After an edge where `in_valid` was low and reset was inactive, `prod_out` keeps its previous value.
- R5: A synchronous active-high `rst` clears `out_valid` to 0 and `prod_out` to 0 at the next edge.
- R6: With every error-prone bit flipped (mask bits M..2L−1 all ones), the output is still exact for zero, one, maximum and mixed operands.
- R7: The replica estimate never exceeds the true product and falls short of it by less than 2^M for every operand pair, including both operands at their maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on this cycle are to be multiplied |
| op_a | input | L | First unsigned operand |
| op_b | input | L | Second unsigned operand |
| err_mask | input | 2L | XOR fault pattern for the main multiplier's result; low M bits ignored |
| out_valid | output | 1 | `prod_out` holds a new result |
| prod_out | output | 2L | Registered exact product |

## Verification
Several properties are checked on every cycle by assertions. These are the residual bound between the replica and the true product, the confinement of injected faults to the error-prone field, the one-cycle valid timing, the hold on idle cycles, the reset clear, and the exactness of each registered product against the operands from the cycle before. Other behaviours can only be shown by the bench's scenarios. These are the extreme operand pairs under a fully set fault mask, masks confined to the safe field, and a reset arriving between valid results, with each output compared against a product computed independently in the bench.

// File: rtl/ovs_mult.sv
module ovs_mult #(
  parameter int L = 16,
  parameter int M = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [L-1:0]       op_a,
  input  logic [L-1:0]       op_b,
  input  logic [2*L-1:0]     err_mask,
  output logic               out_valid,
  output logic [2*L-1:0]     prod_out
);

  localparam int N    = 2 * L;
  localparam int P    = 2 * L - M + 1;
  localparam int DROP = L - P;
  localparam logic [L-1:0] KEEP_HI = ~((L'(1) << DROP) - L'(1));
  localparam logic [N-1:0] EP_FIELD = ~((N'(1) << M) - N'(1));

  if (!(P < L) || !(M < N)) begin : g_cfg_check
    $error("ovs_mult: need P = 2L-M+1 below L and M below 2L");
  end

  // main multiplier, then fault injection on the error-prone field
  logic [N-1:0] tgt_prod, noisy;
  assign tgt_prod = N'(op_a) * N'(op_b);
  assign noisy    = tgt_prod ^ (err_mask & EP_FIELD);

  // reduced-precision replica on the top P bits of each operand
  logic [L-1:0] a_hi, b_hi;
  logic [N-1:0] est;
  assign a_hi = op_a & KEEP_HI;
  assign b_hi = op_b & KEEP_HI;
  assign est  = N'(a_hi) * N'(b_hi);

  // correction: damage = field-aligned part of (noisy - estimate)
  logic [N-1:0] diff, damage, fixed;
  assign diff   = noisy - est;
  assign damage = diff & EP_FIELD;
  assign fixed  = noisy - damage;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prod_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) prod_out <= fixed;
    end
  end

  always_comb begin
    if (rst === 1'b0) begin
      a_resid_bound_r7: assert (tgt_prod >= est && (tgt_prod - est) < (N'(1) << M));
      a_safe_field_r2:  assert (noisy[M-1:0] == tgt_prod[M-1:0]);
    end
  end

  p_exact_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> prod_out == (N'($past(op_a)) * N'($past(op_b))));

  p_valid_follow_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prod_out));

  p_reset_clear_r5: assert property (@(posedge clk)
    rst |=> (!out_valid && prod_out == '0));

endmodule

// File: tb/ovs_mult_tb_top.sv
module ovs_mult_tb_top;
  localparam int L = 16;
  localparam int M = 20;
  localparam int N = 2 * L;
  localparam logic [N-1:0] EP_ALL = ~((N'(1) << M) - N'(1));
  localparam logic [N-1:0] SAFE_ALL = (N'(1) << M) - N'(1);
  localparam logic [L-1:0] MAXV = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [L-1:0] op_a = '0, op_b = '0;
  logic [N-1:0] err_mask = '0;
  logic out_valid;
  logic [N-1:0] prod_out;

  int tests = 0;
  int fails = 0;
  logic [N-1:0] exp_p = '0;
  logic exp_v = 1'b0;

  always #10 clk = ~clk;

  ovs_mult #(.L(L), .M(M)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .err_mask(err_mask), .out_valid(out_valid), .prod_out(prod_out)
  );

  function automatic logic [N-1:0] ref_mul(logic [L-1:0] a, logic [L-1:0] b);
    return N'(a) * N'(b);
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // called at a negedge: drive, wait one edge, check at next negedge
  task automatic step(logic v, logic [L-1:0] a, logic [L-1:0] b, logic [N-1:0] mk, string req);
    in_valid = v; op_a = a; op_b = b; err_mask = mk;
    if (v) exp_p = ref_mul(a, b);
    exp_v = v;
    @(negedge clk);
    chk(req, prod_out, exp_p);
    chk({req, " valid (R3)"}, N'(out_valid), N'(exp_v));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c4a));
    repeat (3) @(negedge clk);
    chk("R5 reset product", prod_out, '0);
    chk("R5 reset valid", N'(out_valid), '0);
    rst = 1'b0;

    step(1'b1, 16'd3, 16'd5, '0, "R1 small");
    step(1'b1, 16'd0, MAXV, EP_ALL, "R6 zero x max");
    step(1'b1, 16'd1, MAXV, EP_ALL, "R6 one x max");
    step(1'b1, MAXV, MAXV, EP_ALL, "R7 max x max full mask");
    step(1'b1, MAXV, MAXV, '0, "R7 max x max clean");
    step(1'b1, 16'h8001, 16'h7fff, EP_ALL, "R6 mixed");
    step(1'b1, 16'h000f, 16'h0fff, SAFE_ALL, "R2 safe-field mask ignored");
    step(1'b1, 16'hffff, 16'h0001, N'(1) << M, "R2 lowest error-prone bit");
    step(1'b1, 16'h1234, 16'h5678, N'(1) << (N - 1), "R2 top bit flip");
    step(1'b0, 16'h9999, 16'h9999, EP_ALL, "R4 idle hold");
    step(1'b0, 16'h0001, 16'h0001, '0, "R4 idle hold again");
    step(1'b1, 16'h00ff, 16'hff00, EP_ALL, "R1 after idle");

    rst = 1'b1;
    exp_p = '0; exp_v = 1'b0;
    @(negedge clk);
    chk("R5 mid-run reset product", prod_out, '0);
    chk("R5 mid-run reset valid", N'(out_valid), '0);
    rst = 1'b0;

    for (int i = 0; i < 400; i++) begin
      logic [L-1:0] a, b;
      logic [N-1:0] mk;
      logic v;
      a = L'($urandom);
      b = L'($urandom);
      mk = N'($urandom);
      v = ($urandom % 4) != 0;
      if (i % 7 == 0) a = MAXV;
      step(v, a, b, mk, v ? "R1 random" : "R4 random idle");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule